// File: doc/BRIEF.md
# Interrupt Request Arbitration Unit

This block sits between three interrupt lines of an 8-bit processor and its instruction sequencer. The three lines are a non-maskable line, a maskable normal line and a maskable fast line. The non-maskable line is captured into a request latch. That latch stays disarmed from reset until software has given the stack pointer a value. The two maskable lines are level sensitive, and each is gated by its own mask bit from the condition code register.

The sequencer drives the block through short strobes:
- `entryCheck` asks which cause to service once entry has begun.
- `syncReq` parks the block in the wait-for-interrupt state.
- `rtiPop` hands over the condition code byte just pulled from the stack.
- `nmiDone` releases the non-maskable acknowledge.

The block answers with one-cycle decision pulses and a 3-bit vector select. The decisions are: take the interrupt, resume at the next instruction, run a return sequence because the cause was spurious, or restore all or part of the saved registers.

Vector select codes: reset `111`, non-maskable `110`, normal `100`, fast `011`.

Top module: `irq_arb_top`

## Requirements
- R1: A synchronous reset sets `vecSel` to `111`, clears every decision output, `nmiAck` and `syncWait`, and disarms the non-maskable request.
- R2: While disarmed, a high `nmiIn` is never latched. A cycle with `spLoad` or `spPullLo` high arms the request for good, until the next reset.
- R3: When armed and `nmiAck` is low, a sampled high `nmiIn` sets the request latch, which survives the input dropping. The latch clears only on an edge where `nmiIn` is low and `nmiAck` is high.
- R4: Taking a non-maskable interrupt sets `nmiAck`. It stays set until a `nmiDone` cycle. While it is set, a new high `nmiIn` is not latched.
- R5: On `entryCheck` the cause is chosen in priority order: latched non-maskable request, then `irqIn` with `maskIrq` low, then `firqIn` with `maskFirq` low. The choice pulses `takeInt` one cycle after the strobe and loads `vecSel` with `110`, `100` or `011`.
- R6: If `entryCheck` finds no eligible cause, `spuriousRti` pulses instead, `vecSel` keeps its value, and at most one of the five decision outputs is high in any cycle.
- R7: After `syncReq`, `syncWait` is high and no decision is issued while no line is active. A line that is high for one sampled cycle ends the wait.
- R8: In the wait state the first active line in the order non-maskable, normal, fast selects the vector. If that line is unmasked (the non-maskable line always is), `takeInt` pulses.
- R9: In the wait state, if that first active line has its mask bit set, `resumeNext` pulses with that line's vector selected. This holds even when a lower-priority line is unmasked.
- R10: Two cycles after an `rtiPop` strobe, `rtiFull` pulses if the `poppedEntire` value sampled with the strobe was 1, and `rtiPartial` pulses if it was 0. Later changes of `poppedEntire` have no effect.
- R11: While `hold` is high, every register, including the decision outputs, keeps its value and all strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freezes all state while high |
| nmiIn | input | 1 | Non-maskable interrupt line |
| irqIn | input | 1 | Normal interrupt line, level sensitive |
| firqIn | input | 1 | Fast interrupt line, level sensitive |
| maskIrq | input | 1 | Mask bit for the normal line |
| maskFirq | input | 1 | Mask bit for the fast line |
| spLoad | input | 1 | Stack pointer loaded as a whole |
| spPullLo | input | 1 | Stack pointer low byte pulled from memory |
| entryCheck | input | 1 | Sequencer asks for the cause to service |
| syncReq | input | 1 | Enter the wait-for-interrupt state |
| rtiPop | input | 1 | Condition code byte popped during return |
| poppedEntire | input | 1 | Entire-state flag of the popped byte |
| nmiDone | input | 1 | Releases the non-maskable acknowledge |
| vecSel | output | 3 | Vector select code |
| takeInt | output | 1 | Pulse: enter the interrupt |
| resumeNext | output | 1 | Pulse: continue at next instruction |
| spuriousRti | output | 1 | Pulse: no cause, run a return sequence |
| rtiFull | output | 1 | Pulse: restore the whole register set |
| rtiPartial | output | 1 | Pulse: restore only the short frame |
| nmiAck | output | 1 | Non-maskable acknowledge |
| syncWait | output | 1 | High while in the wait state |

## Verification
Entry checks are driven with:
- both maskable lines unmasked, which shows that normal beats fast;
- only the normal line masked, which shows the mask gate;
- both lines masked, which yields the spurious path;
- a latched non-maskable request alongside the normal line, which shows the top priority.

The wait state is exercised as follows:
- A single-cycle unmasked fast pulse separates take from resume and shows that one sample is enough.
- A masked normal line next to an unmasked fast line shows that the order of lines wins over the masks.
- The non-maskable line shows its two-cycle path through the latch.

The non-maskable sequences check the latch against several stimuli:
- input pulses before arming;
- pulses during a pending acknowledge;
- an input held high across `nmiDone`.

This separates arming from acknowledge blocking and from the input-low clear rule.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int VEC_W = 3;

  localparam logic [VEC_W-1:0] VEC_RESET = 3'b111;
  localparam logic [VEC_W-1:0] VEC_NMI   = 3'b110;
  localparam logic [VEC_W-1:0] VEC_IRQ   = 3'b100;
  localparam logic [VEC_W-1:0] VEC_FIRQ  = 3'b011;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SYNC = 2'd1,
    ST_RTI  = 2'd2
  } ctl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadVec;
    logic [VEC_W-1:0] vecCode;
    logic             setAck;
    logic             grabCc;
  } dp_strobe_t;

endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             nmiIn,
  input  logic             spLoad,
  input  logic             spPullLo,
  input  logic             nmiDone,
  input  logic             poppedEntire,
  input  dp_strobe_t       strobe,
  output logic             nmiPend,
  output logic             ccEntire,
  output logic [VEC_W-1:0] vecSel,
  output logic             nmiAck
);

  logic nmiArmed;
  logic nmiReq;

  // arming: disarmed from reset until the stack pointer gets a value
  always_ff @(posedge clk) begin
    if (rst) begin
      nmiArmed <= 1'b0;
    end else if (!hold) begin
      if (spLoad || spPullLo) nmiArmed <= 1'b1;
    end
  end

  // request latch: set on high input when armed and not acknowledged,
  // cleared once the line is low with acknowledge still set
  always_ff @(posedge clk) begin
    if (rst) begin
      nmiReq <= 1'b0;
    end else if (!hold) begin
      if (nmiIn && !nmiAck && nmiArmed)
        nmiReq <= 1'b1;
      else if (!nmiIn && nmiAck)
        nmiReq <= 1'b0;
    end
  end

  // acknowledge: set when taken, released by the sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      nmiAck <= 1'b0;
    end else if (!hold) begin
      if (strobe.setAck)
        nmiAck <= 1'b1;
      else if (nmiDone)
        nmiAck <= 1'b0;
    end
  end

  // vector select and popped entire-state flag
  always_ff @(posedge clk) begin
    if (rst) begin
      vecSel   <= VEC_RESET;
      ccEntire <= 1'b0;
    end else if (!hold) begin
      if (strobe.loadVec) vecSel   <= strobe.vecCode;
      if (strobe.grabCc)  ccEntire <= poppedEntire;
    end
  end

  assign nmiPend = nmiReq && !nmiAck;

  a_r2_disarmed_no_latch: assert property (@(posedge clk) disable iff (rst)
    (!hold && !nmiArmed && !nmiReq) |=> !nmiReq)
    else $error("R2: request latched while disarmed");

  a_r3_req_kept_while_high: assert property (@(posedge clk) disable iff (rst)
    (!hold && nmiReq && nmiIn) |=> nmiReq)
    else $error("R3: request dropped while input high");

  a_r4_ack_kept: assert property (@(posedge clk) disable iff (rst)
    (!hold && nmiAck && !nmiDone) |=> nmiAck)
    else $error("R4: acknowledge dropped without release");

  a_r11_hold_freezes_vec: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(vecSel))
    else $error("R11: vector changed during hold");

endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       entryCheck,
  input  logic       syncReq,
  input  logic       rtiPop,
  input  logic       irqIn,
  input  logic       firqIn,
  input  logic       maskIrq,
  input  logic       maskFirq,
  input  logic       nmiPend,
  input  logic       ccEntire,
  output dp_strobe_t strobe,
  output logic       takeInt,
  output logic       resumeNext,
  output logic       spuriousRti,
  output logic       rtiFull,
  output logic       rtiPartial,
  output logic       syncWait
);

  ctl_state_e state, stateNxt;
  logic takeNxt, resumeNxt, spurNxt, fullNxt, partNxt;

  always_comb begin
    stateNxt       = state;
    strobe         = '0;
    strobe.vecCode = VEC_RESET;
    takeNxt        = 1'b0;
    resumeNxt      = 1'b0;
    spurNxt        = 1'b0;
    fullNxt        = 1'b0;
    partNxt        = 1'b0;
    case (state)
      ST_RUN: begin
        if (entryCheck) begin
          if (nmiPend) begin
            strobe.loadVec = 1'b1;
            strobe.vecCode = VEC_NMI;
            strobe.setAck  = 1'b1;
            takeNxt        = 1'b1;
          end else if (irqIn && !maskIrq) begin
            strobe.loadVec = 1'b1;
            strobe.vecCode = VEC_IRQ;
            takeNxt        = 1'b1;
          end else if (firqIn && !maskFirq) begin
            strobe.loadVec = 1'b1;
            strobe.vecCode = VEC_FIRQ;
            takeNxt        = 1'b1;
          end else begin
            spurNxt = 1'b1;
          end
        end else if (syncReq) begin
          stateNxt = ST_SYNC;
        end else if (rtiPop) begin
          strobe.grabCc = 1'b1;
          stateNxt      = ST_RTI;
        end
      end
      ST_SYNC: begin
        if (nmiPend) begin
          strobe.loadVec = 1'b1;
          strobe.vecCode = VEC_NMI;
          strobe.setAck  = 1'b1;
          takeNxt        = 1'b1;
          stateNxt       = ST_RUN;
        end else if (irqIn) begin
          strobe.loadVec = 1'b1;
          strobe.vecCode = VEC_IRQ;
          takeNxt        = !maskIrq;
          resumeNxt      = maskIrq;
          stateNxt       = ST_RUN;
        end else if (firqIn) begin
          strobe.loadVec = 1'b1;
          strobe.vecCode = VEC_FIRQ;
          takeNxt        = !maskFirq;
          resumeNxt      = maskFirq;
          stateNxt       = ST_RUN;
        end
      end
      ST_RTI: begin
        fullNxt  = ccEntire;
        partNxt  = !ccEntire;
        stateNxt = ST_RUN;
      end
      default: stateNxt = ST_RUN;
    endcase
    if (hold) begin
      strobe = '0;
      strobe.vecCode = VEC_RESET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      takeInt     <= 1'b0;
      resumeNext  <= 1'b0;
      spuriousRti <= 1'b0;
      rtiFull     <= 1'b0;
      rtiPartial  <= 1'b0;
    end else if (!hold) begin
      state       <= stateNxt;
      takeInt     <= takeNxt;
      resumeNext  <= resumeNxt;
      spuriousRti <= spurNxt;
      rtiFull     <= fullNxt;
      rtiPartial  <= partNxt;
    end
  end

  assign syncWait = (state == ST_SYNC);

  a_r7_wait_persists: assert property (@(posedge clk) disable iff (rst)
    (!hold && syncWait && !nmiPend && !irqIn && !firqIn) |=> (syncWait && !takeInt && !resumeNext))
    else $error("R7: wait left without a cause");

  a_r9_masked_resumes: assert property (@(posedge clk) disable iff (rst)
    (!hold && syncWait && !nmiPend && irqIn && maskIrq) |=> (resumeNext && !takeInt))
    else $error("R9: masked line in wait did not resume");

  a_r10_rti_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rtiFull && rtiPartial))
    else $error("R10: both restore pulses high");

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             nmiIn,
  input  logic             irqIn,
  input  logic             firqIn,
  input  logic             maskIrq,
  input  logic             maskFirq,
  input  logic             spLoad,
  input  logic             spPullLo,
  input  logic             entryCheck,
  input  logic             syncReq,
  input  logic             rtiPop,
  input  logic             poppedEntire,
  input  logic             nmiDone,
  output logic [VEC_W-1:0] vecSel,
  output logic             takeInt,
  output logic             resumeNext,
  output logic             spuriousRti,
  output logic             rtiFull,
  output logic             rtiPartial,
  output logic             nmiAck,
  output logic             syncWait
);

  dp_strobe_t strobe;
  logic nmiPend;
  logic ccEntire;

  irq_arb_datapath u_dp (
    .clk          (clk),
    .rst          (rst),
    .hold         (hold),
    .nmiIn        (nmiIn),
    .spLoad       (spLoad),
    .spPullLo     (spPullLo),
    .nmiDone      (nmiDone),
    .poppedEntire (poppedEntire),
    .strobe       (strobe),
    .nmiPend      (nmiPend),
    .ccEntire     (ccEntire),
    .vecSel       (vecSel),
    .nmiAck       (nmiAck)
  );

  irq_arb_control u_ctl (
    .clk         (clk),
    .rst         (rst),
    .hold        (hold),
    .entryCheck  (entryCheck),
    .syncReq     (syncReq),
    .rtiPop      (rtiPop),
    .irqIn       (irqIn),
    .firqIn      (firqIn),
    .maskIrq     (maskIrq),
    .maskFirq    (maskFirq),
    .nmiPend     (nmiPend),
    .ccEntire    (ccEntire),
    .strobe      (strobe),
    .takeInt     (takeInt),
    .resumeNext  (resumeNext),
    .spuriousRti (spuriousRti),
    .rtiFull     (rtiFull),
    .rtiPartial  (rtiPartial),
    .syncWait    (syncWait)
  );

  a_r6_single_decision: assert property (@(posedge clk) disable iff (rst)
    $onehot0({takeInt, resumeNext, spuriousRti, rtiFull, rtiPartial}))
    else $error("R6: more than one decision pulse");

  a_r5_take_has_vector: assert property (@(posedge clk) disable iff (rst)
    takeInt |-> (vecSel != VEC_RESET))
    else $error("R5: interrupt taken with reset vector");

endmodule

// File: tb/irq_arb_top_test.sv
`timescale 1ns/1ps
module irq_arb_top_test;

  logic clk = 1'b0;
  logic rst, hold, nmiIn, irqIn, firqIn, maskIrq, maskFirq;
  logic spLoad, spPullLo, entryCheck, syncReq, rtiPop, poppedEntire, nmiDone;
  logic [2:0] vecSel;
  logic takeInt, resumeNext, spuriousRti, rtiFull, rtiPartial, nmiAck, syncWait;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  irq_arb_top uut (
    .clk(clk), .rst(rst), .hold(hold), .nmiIn(nmiIn), .irqIn(irqIn),
    .firqIn(firqIn), .maskIrq(maskIrq), .maskFirq(maskFirq),
    .spLoad(spLoad), .spPullLo(spPullLo), .entryCheck(entryCheck),
    .syncReq(syncReq), .rtiPop(rtiPop), .poppedEntire(poppedEntire),
    .nmiDone(nmiDone), .vecSel(vecSel), .takeInt(takeInt),
    .resumeNext(resumeNext), .spuriousRti(spuriousRti), .rtiFull(rtiFull),
    .rtiPartial(rtiPartial), .nmiAck(nmiAck), .syncWait(syncWait)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    hold = 0; nmiIn = 0; irqIn = 0; firqIn = 0; maskIrq = 0; maskFirq = 0;
    spLoad = 0; spPullLo = 0; entryCheck = 0; syncReq = 0; rtiPop = 0;
    poppedEntire = 0; nmiDone = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1;
    step(3);
    rst = 0;
  endtask

  task automatic pulse_entry();
    entryCheck = 1; step(); entryCheck = 0;
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    check("R1", "vecSel", vecSel, 7);
    check("R1", "decisions", {takeInt, resumeNext, spuriousRti, rtiFull, rtiPartial}, 0);
    check("R1", "nmiAck", nmiAck, 0);
    check("R1", "syncWait", syncWait, 0);
  endtask

  // R2, R6: disarmed nmi ignored
  task automatic t_disarmed();
    do_reset();
    nmiIn = 1; step(3); nmiIn = 0; step();
    pulse_entry();
    check("R2", "spurious while disarmed", spuriousRti, 1);
    check("R2", "no take while disarmed", takeInt, 0);
    check("R6", "vecSel unchanged", vecSel, 7);
    step();
    check("R6", "spurious is one cycle", spuriousRti, 0);
  endtask

  // R2, R3, R4
  task automatic t_nmi_pull_lo();
    do_reset();
    spPullLo = 1; step(); spPullLo = 0;
    nmiIn = 1; step(); nmiIn = 0; step(2);
    pulse_entry();
    check("R3", "latched nmi taken", takeInt, 1);
    check("R5", "nmi vector", vecSel, 6);
    check("R4", "ack set", nmiAck, 1);
    step();
    nmiIn = 1; step(2); nmiIn = 0; step();
    check("R4", "ack still set", nmiAck, 1);
    nmiDone = 1; step(); nmiDone = 0;
    check("R4", "ack released", nmiAck, 0);
    pulse_entry();
    check("R4", "nmi during ack not latched", spuriousRti, 1);
    step();
    // input held high across release keeps the request
    nmiIn = 1; step();
    pulse_entry();
    check("R3", "second nmi taken", takeInt, 1);
    step();
    nmiDone = 1; step(); nmiDone = 0;
    pulse_entry();
    check("R3", "request kept while input high", takeInt, 1);
    check("R3", "vector nmi", vecSel, 6);
    nmiIn = 0; step();
    nmiDone = 1; step(); nmiDone = 0;
    pulse_entry();
    check("R3", "request cleared after low with ack", spuriousRti, 1);
    step();
  endtask

  // R2 via whole load
  task automatic t_nmi_load();
    do_reset();
    spLoad = 1; step(); spLoad = 0;
    nmiIn = 1; step(); nmiIn = 0;
    pulse_entry();
    check("R2", "armed by whole load", takeInt, 1);
    check("R2", "vector nmi", vecSel, 6);
    step();
    nmiDone = 1; step(); nmiDone = 0;
  endtask

  // R5, R6
  task automatic t_priority();
    do_reset();
    irqIn = 1; firqIn = 1;
    pulse_entry();
    check("R5", "normal beats fast", vecSel, 4);
    check("R5", "take", takeInt, 1);
    step();
    maskIrq = 1;
    pulse_entry();
    check("R5", "fast when normal masked", vecSel, 3);
    step();
    maskFirq = 1;
    pulse_entry();
    check("R6", "both masked spurious", spuriousRti, 1);
    check("R6", "vector kept", vecSel, 3);
    step();
    maskIrq = 0; maskFirq = 0;
    spLoad = 1; step(); spLoad = 0;
    nmiIn = 1; step();
    pulse_entry();
    check("R5", "nmi beats normal", vecSel, 6);
    nmiIn = 0; irqIn = 0; firqIn = 0; step();
    nmiDone = 1; step(); nmiDone = 0;
  endtask

  // R7, R8, R9
  task automatic t_sync();
    do_reset();
    syncReq = 1; step(); syncReq = 0;
    check("R7", "waiting", syncWait, 1);
    step(3);
    check("R7", "still waiting", syncWait, 1);
    check("R7", "no decision", {takeInt, resumeNext}, 0);
    firqIn = 1; step(); firqIn = 0;
    check("R8", "one-cycle fast taken", takeInt, 1);
    check("R8", "fast vector", vecSel, 3);
    check("R7", "wait left", syncWait, 0);
    step();
    syncReq = 1; step(); syncReq = 0;
    irqIn = 1; maskIrq = 1; firqIn = 1; maskFirq = 0; step();
    irqIn = 0; firqIn = 0;
    check("R9", "masked normal resumes", resumeNext, 1);
    check("R9", "no take", takeInt, 0);
    check("R9", "normal vector", vecSel, 4);
    step();
    syncReq = 1; step(); syncReq = 0;
    maskFirq = 1; firqIn = 1; step(); firqIn = 0;
    check("R9", "masked fast resumes", resumeNext, 1);
    check("R9", "fast vector", vecSel, 3);
    step();
    spLoad = 1; step(); spLoad = 0;
    syncReq = 1; step(); syncReq = 0;
    nmiIn = 1; step(); nmiIn = 0;
    check("R8", "nmi latching, still waiting", syncWait, 1);
    step();
    check("R8", "nmi taken in wait", takeInt, 1);
    check("R8", "nmi vector", vecSel, 6);
    step();
    nmiDone = 1; step(); nmiDone = 0;
  endtask

  // R10
  task automatic t_rti();
    do_reset();
    rtiPop = 1; poppedEntire = 1; step(); rtiPop = 0; poppedEntire = 0;
    check("R10", "not yet", rtiFull, 0);
    step();
    check("R10", "full restore", rtiFull, 1);
    check("R10", "no partial", rtiPartial, 0);
    step();
    rtiPop = 1; poppedEntire = 0; step(); rtiPop = 0; poppedEntire = 1;
    step();
    check("R10", "partial from popped value", rtiPartial, 1);
    check("R10", "no full", rtiFull, 0);
    poppedEntire = 0; step();
  endtask

  // R11
  task automatic t_hold();
    do_reset();
    irqIn = 1; hold = 1; entryCheck = 1; step(3);
    check("R11", "no take during hold", takeInt, 0);
    check("R11", "vector frozen", vecSel, 7);
    entryCheck = 0; hold = 0; step();
    check("R11", "strobe ignored", takeInt, 0);
    pulse_entry();
    check("R11", "take after hold", takeInt, 1);
    hold = 1; step(2);
    check("R11", "pulse frozen", takeInt, 1);
    hold = 0; step();
    check("R11", "pulse clears after hold", takeInt, 0);
    irqIn = 0;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nFails++;
        nChecks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    t_reset();
    t_disarmed();
    t_nmi_pull_lo();
    t_nmi_load();
    t_priority();
    t_sync();
    t_rti();
    t_hold();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule